// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the synchronous control core of a 12-bit successive-approximation converter. It watches two external strobes, a conversion-start line and an active-low chip-select line. It decides when the input is being sampled and when a conversion runs. During a conversion it walks a binary search from the most significant bit down, and an external comparator bit settles each trial. The analog array is outside the block: the trial word goes out on `trial_o`, and the comparator answer comes back on `cmp_ge_i`.

Each strobe can open a sampling window or close one, depending on the level of the other strobe. While a conversion runs, the busy flag is high. Dropping chip-select while conversion-start is high aborts the conversion and loads a fixed marker code into the result register. If both strobes are held in the right state, a new sampling window opens as soon as a conversion finishes, so conversions can run back to back. The result register keeps the previous word until a new conversion finishes, so a read made during conversion N returns word N-1. Both strobes pass through a two-flop synchronizer before their edges are detected, so the block reacts to a strobe edge on the third clock edge after it.

Top module: `sar_sequencer`

## Requirements
- R1: With the block idle, chip-select low and busy low, a rising conversion-start edge opens a sampling window (`sampling_o` = 1). A rising conversion-start edge while chip-select is high has no effect.
- R2: With the block idle and conversion-start high, a falling chip-select edge opens a sampling window.
- R3: When a conversion completes while chip-select is low and conversion-start is high, the block goes straight into sampling. `sampling_o` rises on the same clock edge on which `busy_o` falls.
- R4: A sampling window is closed, and a conversion started, by either of two events: a falling conversion-start edge with chip-select low, or a falling chip-select edge with conversion-start low. `busy_o` rises on the clock edge after the last sampling cycle.
- R5: A conversion that is not aborted keeps `busy_o` high for exactly WIDTH+1 clock cycles: WIDTH trial cycles and one latch cycle. `busy_o` and `sampling_o` are never high together.
- R6: A falling chip-select edge while busy and while conversion-start is high aborts the conversion. On the next cycle `result_o` is ABORT_CODE (default 12'hFE0), `busy_o` is 0 and the block is idle, not sampling.
- R7: Trials run from the most significant bit down. Each bit is kept when `cmp_ge_i` is 1 for the trial word `trial_o` (the bits kept so far plus the bit under test). The result is straight binary: 12'h000 is zero, 12'h800 is midscale and 12'hFFF is full scale.
- R8: `result_o` changes only when a conversion completes or is aborted. Throughout a conversion it holds the previous word.
- R9: During and after reset, `busy_o` = 0, `sampling_o` = 0 and `result_o` = 0.
- R10: A sampling window lasts at least MIN_SAMPLE cycles. A request to end it earlier is held and takes effect at exactly MIN_SAMPLE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | Conversion-start strobe (asynchronous) |
| cs_n_i | input | 1 | Chip select, active low (asynchronous) |
| cmp_ge_i | input | 1 | Comparator: 1 when the input is at or above `trial_o` |
| trial_o | output | WIDTH | Trial word presented to the comparator |
| busy_o | output | 1 | High while a conversion runs |
| sampling_o | output | 1 | High while the input is being sampled |
| result_o | output | WIDTH | Last completed result, or the abort code |

## Verification
The hardest state to reach is an abort. It needs a chip-select fall inside the 13-cycle busy window while conversion-start is already high, and a rise of conversion-start during busy must be ignored before that. The bench builds this ordering in a directed sequence: conversion-start rises during the third busy cycle, and chip-select then goes high for two cycles and falls again. Back-to-back entry is forced the same way, by raising conversion-start while busy. A zero-length sampling hold checks the deferred end of sampling against the exact window length.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_CONV   = 2'd2,
    PH_LATCH  = 2'd3
  } phase_t;
endpackage

// File: rtl/sar_seq_sync.sv
module sar_seq_sync #(
  parameter int N = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
      last_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign cur_o  = sync_q;
  assign prev_o = last_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int MIN_SAMPLE = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cv_lvl,
  input  logic   cs_low,
  input  logic   cv_rise,
  input  logic   cv_fall,
  input  logic   cs_fall,
  input  logic   last_trial,
  output phase_t phase,
  output logic   samp_evt,
  output logic   conv_evt,
  output logic   step_en,
  output logic   latch_evt,
  output logic   abort_evt
);
  localparam int CW = $clog2(MIN_SAMPLE + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(MIN_SAMPLE - 1);

  phase_t        nxt;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          samp_req, conv_req, in_busy;

  always_comb begin
    samp_req  = (cv_rise & cs_low) | (cs_fall & cv_lvl);
    conv_req  = (cv_fall & cs_low) | (cs_fall & ~cv_lvl);
    in_busy   = (phase == PH_CONV) || (phase == PH_LATCH);
    abort_evt = in_busy & cs_fall & cv_lvl;
    samp_evt  = 1'b0;
    conv_evt  = 1'b0;
    latch_evt = 1'b0;
    step_en   = 1'b0;
    nxt       = phase;
    unique case (phase)
      PH_IDLE: if (samp_req) begin
        nxt      = PH_SAMPLE;
        samp_evt = 1'b1;
      end
      PH_SAMPLE: if ((conv_req | pend) && (cnt == CNT_DONE)) begin
        nxt      = PH_CONV;
        conv_evt = 1'b1;
      end
      PH_CONV: if (abort_evt) nxt = PH_IDLE;
      else begin
        step_en = 1'b1;
        if (last_trial) nxt = PH_LATCH;
      end
      PH_LATCH: if (abort_evt) nxt = PH_IDLE;
      else begin
        latch_evt = 1'b1;
        if (cs_low & cv_lvl) begin
          nxt      = PH_SAMPLE;
          samp_evt = 1'b1;
        end else nxt = PH_IDLE;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      phase <= nxt;
      if (samp_evt) begin
        cnt  <= '0;
        pend <= 1'b0;
      end else if (phase == PH_SAMPLE) begin
        if (cnt != CNT_DONE) cnt <= cnt + 1'b1;
        if (conv_req) pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_seq_trials.sv
module sar_seq_trials #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             cmp_ge_i,
  output logic             last_o,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] acc_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  function automatic logic [WIDTH-1:0] keep_bit(input logic [WIDTH-1:0] acc,
                                                input logic [WIDTH-1:0] mask,
                                                input logic ge);
    return ge ? (acc | mask) : acc;
  endfunction

  logic [WIDTH-1:0] acc_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mask_q <= '0;
    end else if (load_i) begin
      acc_q  <= '0;
      mask_q <= TOP_BIT;
    end else if (step_i) begin
      acc_q  <= keep_bit(acc_q, mask_q, cmp_ge_i);
      mask_q <= mask_q >> 1;
    end
  end

  assign trial_o = acc_q | mask_q;
  assign last_o  = mask_q[0];
  assign acc_o   = acc_q;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int               WIDTH      = 12,
  parameter int               MIN_SAMPLE = 4,
  parameter logic [WIDTH-1:0] ABORT_CODE = 12'hFE0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start_i,
  input  logic             cs_n_i,
  input  logic             cmp_ge_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_o,
  output logic             sampling_o,
  output logic [WIDTH-1:0] result_o
);
  logic [1:0] pin_cur, pin_prev;
  logic       cv_lvl, cs_low, cv_rise, cv_fall, cs_fall;
  phase_t     phase;
  logic       samp_evt, conv_evt, step_en, latch_evt, abort_evt, last_trial;
  logic [WIDTH-1:0] acc;

  // bit 1: chip select (idle high), bit 0: conversion start (idle low)
  sar_seq_sync #(.N(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_n_i, conv_start_i}),
    .cur_o(pin_cur), .prev_o(pin_prev)
  );

  assign cv_lvl  = pin_cur[0];
  assign cs_low  = ~pin_cur[1];
  assign cv_rise = pin_cur[0] & ~pin_prev[0];
  assign cv_fall = ~pin_cur[0] & pin_prev[0];
  assign cs_fall = ~pin_cur[1] & pin_prev[1];

  sar_seq_ctrl #(.MIN_SAMPLE(MIN_SAMPLE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cv_lvl(cv_lvl), .cs_low(cs_low),
    .cv_rise(cv_rise), .cv_fall(cv_fall), .cs_fall(cs_fall),
    .last_trial(last_trial), .phase(phase), .samp_evt(samp_evt),
    .conv_evt(conv_evt), .step_en(step_en), .latch_evt(latch_evt),
    .abort_evt(abort_evt)
  );

  sar_seq_trials #(.WIDTH(WIDTH)) u_trials (
    .clk(clk), .rst_n(rst_n), .load_i(conv_evt), .step_i(step_en),
    .cmp_ge_i(cmp_ge_i), .last_o(last_trial), .trial_o(trial_o), .acc_o(acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result_o <= '0;
    else if (abort_evt) result_o <= ABORT_CODE;
    else if (latch_evt) result_o <= acc;
  end

  assign busy_o     = (phase == PH_CONV) || (phase == PH_LATCH);
  assign sampling_o = (phase == PH_SAMPLE);
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
  parameter int               WIDTH      = 12,
  parameter int               MIN_SAMPLE = 4,
  parameter logic [WIDTH-1:0] ABORT_CODE = 12'hFE0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             sampling_o,
  input logic [WIDTH-1:0] result_o,
  input logic             latch_evt,
  input logic             abort_evt
);
  localparam int BW = $clog2(WIDTH + 3);
  localparam int SW = $clog2(MIN_SAMPLE + 2);
  localparam logic [BW-1:0] BMAX = BW'(WIDTH + 2);
  localparam logic [SW-1:0] SMAX = SW'(MIN_SAMPLE);

  logic [BW-1:0] busy_cnt;
  logic [SW-1:0] samp_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      samp_cnt <= '0;
    end else begin
      busy_cnt <= !busy_o ? '0 : (busy_cnt == BMAX ? busy_cnt : busy_cnt + 1'b1);
      samp_cnt <= !sampling_o ? '0 : (samp_cnt == SMAX ? samp_cnt : samp_cnt + 1'b1);
    end
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) ($fell(busy_o) && !$past(abort_evt)) |-> (busy_cnt == BW'(WIDTH + 1))); // R5
  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(busy_o && sampling_o)); // R5
  AST_ABORT_CODE: assert property (@(posedge clk) disable iff (!rst_n) abort_evt |=> (result_o == ABORT_CODE) && !busy_o && !sampling_o); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!latch_evt && !abort_evt) |=> $stable(result_o)); // R8
  AST_MIN_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> (samp_cnt >= SMAX)); // R10
  AST_BUSY_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(sampling_o)); // R4
endmodule

bind sar_sequencer sar_seq_checker #(
  .WIDTH(WIDTH), .MIN_SAMPLE(MIN_SAMPLE), .ABORT_CODE(ABORT_CODE)
) u_checker (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .sampling_o(sampling_o),
  .result_o(result_o), .latch_evt(latch_evt), .abort_evt(abort_evt)
);

// File: tb/sar_sequencer_test.sv
module sar_sequencer_test;
  localparam int W  = 12;
  localparam int MS = 4;
  localparam logic [W-1:0] ABORT = 12'hFE0;

  logic clk = 1'b0, rst_n = 1'b0, cv = 1'b0, cs_n = 1'b1;
  logic [W-1:0] vin = '0, trial, result, prev_res = '0;
  logic busy, sampling, cmp;
  int errors = 0, checks = 0;

  assign cmp = (vin >= trial);
  always #5 clk = ~clk;

  sar_sequencer #(.WIDTH(W), .MIN_SAMPLE(MS), .ABORT_CODE(ABORT)) uut (
    .clk(clk), .rst_n(rst_n), .conv_start_i(cv), .cs_n_i(cs_n), .cmp_ge_i(cmp),
    .trial_o(trial), .busy_o(busy), .sampling_o(sampling), .result_o(result)
  );

  function automatic logic [W-1:0] model_code(input logic [W-1:0] v);
    logic [W-1:0] a = '0;
    for (int b = W - 1; b >= 0; b--) begin
      logic [W-1:0] t = a | (W'(1) << b);
      if (v >= t) a = t;
    end
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts busy cycles from the first busy negedge; checks hold and result
  task automatic run_busy(input logic [W-1:0] v);
    int n = 1;
    chk(result == prev_res, "R8 hold at busy start", result, prev_res);
    repeat (40) begin
      @(negedge clk);
      if (!busy) break;
      n++;
      chk(result == prev_res, "R8 hold during conversion", result, prev_res);
    end
    chk(n == W + 1, "R5 busy length", n, W + 1);
    chk(result == model_code(v), "R7 result code", result, model_code(v));
    prev_res = result;
  endtask

  task automatic run_cv(input logic [W-1:0] v, input int hold);
    int s = 0, t = 0;
    vin = v;
    cv  = 1'b1;
    repeat (80) begin
      @(negedge clk);
      if (busy) break;
      if (sampling) s++;
      if (s > 0) begin
        if (t == hold) cv = 1'b0;
        t++;
      end
    end
    chk(s > 0, "R1 sampling after start rise", s, 1);
    chk(busy == 1'b1, "R4 conversion after start fall", busy, 1);
    if (hold == 0) chk(s == MS, "R10 deferred end of sampling", s, MS);
    else chk(s >= MS, "R10 minimum sampling", s, MS);
    run_busy(v);
    tick(2);
  endtask

  task automatic run_cs(input logic [W-1:0] v, input int hold);
    int s = 0;
    cs_n = 1'b1; cv = 1'b0; tick(4);
    vin = v; cv = 1'b1; tick(5);
    chk(sampling == 1'b0, "R1 start rise ignored with cs high", sampling, 0);
    cs_n = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (sampling) begin s = 1; break; end
    end
    chk(s == 1, "R2 sampling after cs fall", s, 1);
    tick(hold);
    cs_n = 1'b1; tick(2);
    cv = 1'b0; tick(2);
    cs_n = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (busy) break;
    end
    chk(busy == 1'b1, "R4 conversion after cs fall", busy, 1);
    run_busy(v);
    tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    chk(busy == 1'b0, "R9 busy in reset", busy, 0);
    chk(sampling == 1'b0, "R9 sampling in reset", sampling, 0);
    chk(result == '0, "R9 result in reset", result, 0);
    rst_n = 1'b1;
    tick(3);
    chk(busy == 1'b0 && sampling == 1'b0, "R9 idle after reset", {busy, sampling}, 0);
    cs_n = 1'b0; tick(3);

    // corner codes through the start-strobe path
    run_cv(12'h000, 0);
    run_cv(12'hFFF, 2);
    run_cv(12'h800, 6);
    run_cv(12'h7FF, 1);

    // chip-select path
    run_cs(12'h5A3, 0);
    run_cs(12'h001, 3);

    // back-to-back: start strobe raised while busy
    begin
      int s = 0;
      vin = 12'h3C7; cv = 1'b1;
      repeat (20) begin @(negedge clk); if (sampling) break; end
      cv = 1'b0;
      repeat (40) begin @(negedge clk); if (busy) break; end
      tick(2);
      cv = 1'b1;
      repeat (40) begin @(negedge clk); if (!busy) break; end
      chk(sampling == 1'b1, "R3 sampling as busy falls", sampling, 1);
      chk(result == 12'h3C7, "R7 back-to-back first result", result, 12'h3C7);
      prev_res = result;
      vin = 12'hA5E; tick(3);
      cv = 1'b0;
      repeat (40) begin @(negedge clk); if (busy) break; s++; end
      chk(busy == 1'b1, "R3 second conversion starts", busy, 1);
      run_busy(12'hA5E);
      tick(2);
    end

    // abort: start high during busy, then chip-select fall
    begin
      int n = 1;
      vin = 12'h123; cv = 1'b1;
      repeat (20) begin @(negedge clk); if (sampling) break; end
      cv = 1'b0;
      repeat (40) begin @(negedge clk); if (busy) break; end
      tick(2);
      cv = 1'b1; tick(1);
      cs_n = 1'b1; tick(2);
      cs_n = 1'b0;
      repeat (40) begin @(negedge clk); if (!busy) break; n++; end
      chk(n < W + 1, "R6 abort shortens busy", n, W + 1);
      chk(result == ABORT, "R6 abort code", result, ABORT);
      tick(3);
      chk(sampling == 1'b0 && busy == 1'b0, "R6 idle after abort", {busy, sampling}, 0);
      chk(result == ABORT, "R8 abort code held", result, ABORT);
      prev_res = result;
      cv = 1'b0; tick(3);
    end

    // constrained random mix of both paths
    for (int i = 0; i < 30; i++) begin
      logic [W-1:0] v = W'($urandom);
      int hold = int'($urandom % 8);
      if ($urandom % 2 == 0) begin
        cs_n = 1'b0; cv = 1'b0; tick(3);
        run_cv(v, hold);
      end else begin
        run_cs(v, hold);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule